// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block issues a single command toward a memory-card model and collects whatever that model sends back. Software writes an 11-bit command word together with a 32-bit argument. If the enable bit of the word is set and the block is idle, it raises a request toward the card that carries the command index and the argument. It then waits for the card's reply. The reply carries an error flag, a byte count and up to sixteen bytes.

The reply is checked against the kind of response the command asked for. Accepted response bytes are packed big-endian into four 32-bit response words. One of three status pulses then reports the outcome: response received, command sent (no response expected), or timeout. The enable bit in the readable command register clears by itself when the command finishes, whether it succeeded or failed. A busy output covers the whole exchange. Serial bit timing, CRC checking, and the interrupt-wait and pending modes are not part of this block. Their bits are only stored.

Top module: `cmd_seq`

## Requirements
- R1: Command word fields are index = bits 5:0, response wanted = bit 6, long response = bit 7, bits 8 and 9 stored only, enable = bit 10. A write with bit 10 set while idle raises `req_valid` on the next cycle, with `req_index` equal to bits 5:0 and `req_arg` equal to the written argument.
- R2: Response bytes are numbered in arrival order, with byte i at `rsp_data[8i+7:8i]`. Word w is built as {byte 4w, byte 4w+1, byte 4w+2, byte 4w+3}, so byte 0 lands in bits 31:24 of word 0. Word w sits at `resp_words[32w+31:32w]`.
- R3: An accepted 4-byte reply fills word 0 and zeroes words 1 to 3. An accepted 16-byte reply fills all four words with bit 0 of word 3 forced to 0. This holds even when only a short response was asked for.
- R4: A timeout is reported when the card flags an error. When a response is wanted, a timeout is also reported for a count of 0, for a count of 4 with a long response selected, and for any count other than 4 or 16.
- R5: One cycle after the clock edge that samples `rsp_valid` during a request, exactly one status pulse is high for one cycle. `sts_resp_end` means an accepted reply to a command that wanted one. `sts_cmd_sent` means no reply was wanted and no error was flagged. `sts_timeout` covers every other case. The response words change only with `sts_resp_end`.
- R6: `cmd_word_q` shows the last accepted command word. Its bit 10 reads 0 from the cycle of the status pulse onward.
- R7: `busy` rises in the cycle after an accepted enable write and falls in the same cycle the status pulse appears.
- R8: A command write while busy is ignored: `cmd_word_q`, `req_index` and `req_arg` keep their values.
- R9: A write with bit 10 clear while idle updates `cmd_word_q` and issues no request.
- R10: After reset, `busy`, `req_valid`, all status pulses, `cmd_word_q` and all response words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | 11 | Command word being written |
| cmd_arg | input | 32 | Argument written with the command |
| req_valid | output | 1 | Request outstanding toward the card |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Card reply present (sampled while `req_valid`) |
| rsp_err | input | 1 | Card reports a failed command |
| rsp_len | input | 5 | Number of reply bytes |
| rsp_data | input | 128 | Reply bytes, byte i at bits 8i+7:8i |
| cmd_word_q | output | 11 | Readable command register |
| busy | output | 1 | Command in progress |
| resp_words | output | 128 | Four response words, word w at bits 32w+31:32w |
| sts_resp_end | output | 1 | Pulse: response received |
| sts_cmd_sent | output | 1 | Pulse: command sent, no response expected |
| sts_timeout | output | 1 | Pulse: error or bad reply length |

## Verification
An accepted enable write shows up as `req_valid`, `busy` and the request fields one cycle after the write edge. The bench therefore checks them at the falling edge right after that write. A reply held for one cycle is captured at the next rising edge. The status pulse, the response words, the cleared enable bit and the falling `busy` all appear together after that edge, and the bench checks them at the following falling edge. It also checks that the pulse is gone one cycle later. Writes made while busy are followed by a check of the command register and request fields at the next falling edge, before the reply is given.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
    localparam int CMD_W   = 11;
    localparam int IDX_W   = 6;
    localparam int B_WANT  = 6;
    localparam int B_LONG  = 7;
    localparam int B_EN    = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        OUT_SENT    = 2'd0,
        OUT_RESP    = 2'd1,
        OUT_TIMEOUT = 2'd2
    } outcome_e;
endpackage

// File: rtl/cmd_seq_rsp_pack.sv
module cmd_seq_rsp_pack
    import cmd_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5
) (
    input  logic                     want,
    input  logic                     long_sel,
    input  logic                     err,
    input  logic [LEN_W-1:0]         len,
    input  logic [NWORDS*WORD_W-1:0] data,
    output outcome_e                 outcome,
    output logic [NWORDS*WORD_W-1:0] words
);
    localparam int BPW     = WORD_W / 8;
    localparam int SHORT_B = BPW;
    localparam int LONG_B  = NWORDS * BPW;

    logic len_short;
    logic len_full;
    logic bad;
    logic [NWORDS*WORD_W-1:0] raw;

    assign len_short = (len == LEN_W'(SHORT_B));
    assign len_full  = (len == LEN_W'(LONG_B));

    always_comb begin
        bad = err;
        if (want) begin
            if (len == '0)             bad = 1'b1;
            if (long_sel && len_short) bad = 1'b1;
            if (!len_short && !len_full) bad = 1'b1;
        end
        if (bad)       outcome = OUT_TIMEOUT;
        else if (want) outcome = OUT_RESP;
        else           outcome = OUT_SENT;
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign raw[w*WORD_W + WORD_W-1-8*b -: 8] = data[(w*BPW+b)*8 +: 8];
        end
        if (w == 0) begin : g_first
            assign words[WORD_W-1:0] = raw[WORD_W-1:0];
        end else if (w == NWORDS-1) begin : g_last
            assign words[w*WORD_W +: WORD_W] =
                len_full ? {raw[w*WORD_W+1 +: WORD_W-1], 1'b0} : '0;
        end else begin : g_mid
            assign words[w*WORD_W +: WORD_W] = len_full ? raw[w*WORD_W +: WORD_W] : '0;
        end
    end
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
    import cmd_seq_pkg::*;
#(
    parameter int ARG_W  = 32,
    parameter int WORD_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [CMD_W-1:0]         cmd_word,
    input  logic [ARG_W-1:0]         cmd_arg,
    input  logic                     rsp_valid,
    input  outcome_e                 outcome,
    input  logic [NWORDS*WORD_W-1:0] words,
    output logic                     req_valid,
    output logic [CMD_W-1:0]         cmd_q,
    output logic [ARG_W-1:0]         arg_q,
    output logic                     busy,
    output logic [NWORDS*WORD_W-1:0] resp_q,
    output logic                     p_end,
    output logic                     p_sent,
    output logic                     p_to
);
    typedef struct packed {
        seq_state_e               st;
        logic [CMD_W-1:0]         cmd;
        logic [ARG_W-1:0]         arg;
        logic [NWORDS*WORD_W-1:0] resp;
        logic                     p_end;
        logic                     p_sent;
        logic                     p_to;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.p_end  = 1'b0;
        r_d.p_sent = 1'b0;
        r_d.p_to   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    r_d.cmd = cmd_word;
                    r_d.arg = cmd_arg;
                    if (cmd_word[B_EN]) r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.st        = ST_IDLE;
                    r_d.cmd[B_EN] = 1'b0;
                    case (outcome)
                        OUT_RESP: begin
                            r_d.resp  = words;
                            r_d.p_end = 1'b1;
                        end
                        OUT_SENT: r_d.p_sent = 1'b1;
                        default:  r_d.p_to   = 1'b1;
                    endcase
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_valid = (r_q.st == ST_WAIT);
    assign busy      = (r_q.st == ST_WAIT);
    assign cmd_q     = r_q.cmd;
    assign arg_q     = r_q.arg;
    assign resp_q    = r_q.resp;
    assign p_end     = r_q.p_end;
    assign p_sent    = r_q.p_sent;
    assign p_to      = r_q.p_to;
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import cmd_seq_pkg::*;
#(
    parameter int ARG_W  = 32,
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [CMD_W-1:0]         cmd_word,
    input  logic [ARG_W-1:0]         cmd_arg,
    output logic                     req_valid,
    output logic [IDX_W-1:0]         req_index,
    output logic [ARG_W-1:0]         req_arg,
    input  logic                     rsp_valid,
    input  logic                     rsp_err,
    input  logic [LEN_W-1:0]         rsp_len,
    input  logic [NWORDS*WORD_W-1:0] rsp_data,
    output logic [CMD_W-1:0]         cmd_word_q,
    output logic                     busy,
    output logic [NWORDS*WORD_W-1:0] resp_words,
    output logic                     sts_resp_end,
    output logic                     sts_cmd_sent,
    output logic                     sts_timeout
);
    outcome_e                 outcome;
    logic [NWORDS*WORD_W-1:0] packed_words;
    logic [CMD_W-1:0]         cmd_q;

    cmd_seq_rsp_pack #(
        .WORD_W(WORD_W), .NWORDS(NWORDS), .LEN_W(LEN_W)
    ) u_pack (
        .want     (cmd_q[B_WANT]),
        .long_sel (cmd_q[B_LONG]),
        .err      (rsp_err),
        .len      (rsp_len),
        .data     (rsp_data),
        .outcome  (outcome),
        .words    (packed_words)
    );

    cmd_seq_ctrl #(
        .ARG_W(ARG_W), .WORD_W(WORD_W), .NWORDS(NWORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_word  (cmd_word),
        .cmd_arg   (cmd_arg),
        .rsp_valid (rsp_valid),
        .outcome   (outcome),
        .words     (packed_words),
        .req_valid (req_valid),
        .cmd_q     (cmd_q),
        .arg_q     (req_arg),
        .busy      (busy),
        .resp_q    (resp_words),
        .p_end     (sts_resp_end),
        .p_sent    (sts_cmd_sent),
        .p_to      (sts_timeout)
    );

    assign req_index  = cmd_q[IDX_W-1:0];
    assign cmd_word_q = cmd_q;
endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_wr,
    input logic [10:0]  cmd_word,
    input logic         req_valid,
    input logic [5:0]   req_index,
    input logic         rsp_valid,
    input logic         rsp_err,
    input logic [4:0]   rsp_len,
    input logic [10:0]  cmd_word_q,
    input logic         busy,
    input logic [127:0] resp_words,
    input logic         sts_resp_end,
    input logic         sts_cmd_sent,
    input logic         sts_timeout
);
    logic any_sts;
    assign any_sts = sts_resp_end | sts_cmd_sent | sts_timeout;

    assert_req_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_word[10]) |=>
            (req_valid && busy && req_index == $past(cmd_word[5:0])));

    assert_short_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_resp_end && $past(rsp_len) == 5'd4) |-> (resp_words[127:32] == '0));

    assert_last_bit_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_words[96] == 1'b0);

    assert_error_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && rsp_err) |=> sts_timeout);

    assert_one_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_resp_end, sts_cmd_sent, sts_timeout}));

    assert_enable_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_sts |-> !cmd_word_q[10]);

    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_sts |-> (!busy && $past(busy)));

    assert_ignore_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !rsp_valid) |=> $stable(cmd_word_q));
endmodule

bind cmd_seq cmd_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_word     (cmd_word),
    .req_valid    (req_valid),
    .req_index    (req_index),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_len      (rsp_len),
    .cmd_word_q   (cmd_word_q),
    .busy         (busy),
    .resp_words   (resp_words),
    .sts_resp_end (sts_resp_end),
    .sts_cmd_sent (sts_cmd_sent),
    .sts_timeout  (sts_timeout)
);

// File: tb/cmd_seq_tb.sv
module cmd_seq_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [10:0]  cmd_word = '0;
    logic [31:0]  cmd_arg = '0;
    logic         req_valid;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid = 1'b0;
    logic         rsp_err = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_data = '0;
    logic [10:0]  cmd_word_q;
    logic         busy;
    logic [127:0] resp_words;
    logic         sts_resp_end, sts_cmd_sent, sts_timeout;

    int n_chk = 0;
    int n_fail = 0;
    logic [127:0] exp_resp = '0;
    logic [10:0]  exp_cmd = '0;
    logic [31:0]  exp_arg = '0;

    always #4 clk = ~clk;

    cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
        .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .cmd_word_q(cmd_word_q), .busy(busy), .resp_words(resp_words),
        .sts_resp_end(sts_resp_end), .sts_cmd_sent(sts_cmd_sent), .sts_timeout(sts_timeout)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 = sent, 1 = response, 2 = timeout
    function automatic int exp_outcome(input logic [10:0] w, input logic err, input logic [4:0] len);
        if (err) return 2;
        if (!w[6]) return 0;
        if (len == 0) return 2;
        if (w[7] && len == 4) return 2;
        if (len != 4 && len != 16) return 2;
        return 1;
    endfunction

    function automatic logic [127:0] exp_pack(input logic [4:0] len, input logic [127:0] d);
        logic [127:0] r = '0;
        int nw = (len == 16) ? 4 : 1;
        for (int w = 0; w < nw; w++)
            for (int b = 0; b < 4; b++)
                r[w*32 + 31 - 8*b -: 8] = d[(w*4+b)*8 +: 8];
        if (len == 16) r[96] = 1'b0;
        return r;
    endfunction

    task automatic write_cmd(input logic [10:0] w, input logic [31:0] a);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w; cmd_arg = a;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // full command: write, check request, reply after delay, check result
    task automatic run_cmd(input logic [10:0] w, input logic [31:0] a, input int dly,
                           input logic err, input logic [4:0] len, input logic [127:0] d);
        int oc;
        write_cmd(w, a);
        exp_cmd = w; exp_arg = a;
        check("R1 req_valid", 128'(req_valid), 128'(1));
        check("R1 req_index", 128'(req_index), 128'(w[5:0]));
        check("R1 req_arg", 128'(req_arg), 128'(a));
        check("R7 busy high", 128'(busy), 128'(1));
        repeat (dly) @(negedge clk);
        rsp_valid = 1'b1; rsp_err = err; rsp_len = len; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        oc = exp_outcome(w, err, len);
        if (oc == 1) exp_resp = exp_pack(len, d);
        exp_cmd[10] = 1'b0;
        check("R5 resp_end", 128'(sts_resp_end), 128'(oc == 1));
        check("R5 cmd_sent", 128'(sts_cmd_sent), 128'(oc == 0));
        check("R4 timeout", 128'(sts_timeout), 128'(oc == 2));
        check("R2 R3 resp_words", resp_words, exp_resp);
        check("R6 enable cleared", 128'(cmd_word_q), 128'(exp_cmd));
        check("R7 busy low", 128'(busy), 128'(0));
        @(negedge clk);
        check("R5 single pulse",
              128'({sts_resp_end, sts_cmd_sent, sts_timeout}), 128'(0));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy", 128'(busy), 128'(0));
        check("R10 req_valid", 128'(req_valid), 128'(0));
        check("R10 cmd_word_q", 128'(cmd_word_q), 128'(0));
        check("R10 resp", resp_words, 128'(0));
        check("R10 status", 128'({sts_resp_end, sts_cmd_sent, sts_timeout}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 short response with known bytes
        d = 128'h0;
        for (int i = 0; i < 16; i++) d[i*8 +: 8] = 8'(8'h10 + i);
        run_cmd(11'h400 | 11'h040 | 11'd17, 32'hCAFE_0001, 0, 1'b0, 5'd4, d);
        check("R2 byte0 in 31:24", 128'(resp_words[31:24]), 128'(8'h10));
        // R3 long response, bit 0 of word 3 forced clear
        d[127:120] = 8'hFF;
        run_cmd(11'h400 | 11'h0C0 | 11'd2, 32'h1234_5678, 2, 1'b0, 5'd16, d);
        check("R3 word3", 128'(resp_words[127:96]), 128'(32'h1C1D1EFE));
        // R3 short wanted, 16 bytes fills all
        run_cmd(11'h440 | 11'd9, 32'h0, 1, 1'b0, 5'd16, rnd128());
        // R4 timeouts, R5 response words unchanged
        run_cmd(11'h4C0 | 11'd3, 32'h5, 1, 1'b0, 5'd4, rnd128());
        run_cmd(11'h440 | 11'd4, 32'h6, 0, 1'b0, 5'd0, rnd128());
        run_cmd(11'h440 | 11'd5, 32'h7, 3, 1'b0, 5'd7, rnd128());
        run_cmd(11'h440 | 11'd6, 32'h8, 0, 1'b1, 5'd4, rnd128());
        // R5 no response wanted -> command sent, error -> timeout
        run_cmd(11'h400 | 11'd0, 32'h9, 2, 1'b0, 5'd0, rnd128());
        run_cmd(11'h400 | 11'd1, 32'hA, 0, 1'b1, 5'd0, rnd128());

        // R8 write while busy ignored
        write_cmd(11'h440 | 11'd33, 32'hAAAA_0000);
        write_cmd(11'h4BF, 32'h5555_5555);
        check("R8 cmd held", 128'(cmd_word_q), 128'(11'h440 | 11'd33));
        check("R8 index held", 128'(req_index), 128'(6'd33));
        check("R8 arg held", 128'(req_arg), 128'(32'hAAAA_0000));
        @(negedge clk);
        rsp_valid = 1'b1; rsp_len = 5'd4; rsp_data = 128'h0;
        @(negedge clk);
        rsp_valid = 1'b0;
        exp_resp = 128'h0;
        check("R8 completes first cmd", 128'(sts_resp_end), 128'(1));

        // R9 write without enable
        write_cmd(11'h3C5, 32'h1);
        check("R9 reg updated", 128'(cmd_word_q), 128'(11'h3C5));
        check("R9 no request", 128'(req_valid), 128'(0));
        check("R9 not busy", 128'(busy), 128'(0));

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [10:0] w;
            logic [4:0] len;
            int sel;
            w = 11'($urandom) & 11'h0FF;
            w[10] = 1'b1;
            sel = $urandom_range(0, 3);
            len = (sel == 0) ? 5'd4 : (sel == 1) ? 5'd16 : (sel == 2) ? 5'd0 : 5'($urandom);
            run_cmd(w, $urandom, $urandom_range(0, 3), ($urandom_range(0, 7) == 0), len, rnd128());
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule